// File: doc/BRIEF.md
# Delay Tap Window Search Controller

This block finds a good operating point for an adjustable delay element in a memory interface. It steps a tap setting through every value the tap bus can hold, from the lowest to the highest. At each tap it asks an external pattern tester for one pass/fail verdict. While it steps, it tracks where the passing region opens and where it closes. After the last tap it drives the middle of that region onto the tap bus. If no tap passed, it drives a fixed safe tap instead.

Software pulses a start input while the block is idle. It then waits for a one-cycle done pulse, which comes with the chosen tap and a success flag. The tester sees a level request with the tap bus held steady, and it answers with a one-cycle done strobe plus a pass bit. Between two taps the request drops for at least one cycle, so each test is a separate handshake.

Top module: `tap_window_search`

## Requirements
- R1: While reset is asserted and right after it, `tap_o` is 16, and `done_o`, `busy_o`, `success_o` and `test_req_o` are 0.
- R2: A start pulse accepted while idle runs exactly 32 test requests with taps 0, 1, …, 31 in ascending order. This holds even when the passing region has already closed earlier in the sweep.
- R3: While `test_req_o` is high, `tap_o` does not change. The request stays high until the cycle in which `test_done_i` is seen, and it is low for at least one cycle before the next tap's request.
- R4: The lowest tap whose test passes becomes the region start. A later pass never replaces it.
- R5: A failing test that follows a pass closes the region at that failing tap. If the region closes again later, the last closing tap is the one kept.
- R6: When a region has closed at least once, the chosen tap is (start + closing tap) / 2, rounded down.
- R7: When no region has closed but tap 31 passed, the chosen tap is (start + 31) / 2, rounded down.
- R8: When no tap passed, the chosen tap is 16 and `success_o` is 0.
- R9: `done_o` is a one-cycle pulse. In that cycle `tap_o` carries the chosen tap, and `success_o` is 1 exactly when some tap passed. Both values hold after the pulse until the next sweep starts, and `busy_o` is 0 on the cycle after the pulse.
- R10: A start pulse that arrives while a sweep is running is ignored. The sweep still issues 32 requests and gives the same result.
- R11: Every new sweep clears the region state left by the previous sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse from software; only honoured while idle |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| busy_o | output | 1 | High from an accepted start until the done pulse |
| success_o | output | 1 | High when at least one tap passed in the last sweep |
| tap_o | output | 5 | Tap under test during a sweep; chosen tap afterwards |
| test_req_o | output | 1 | Request to the pattern tester for the current tap |
| test_done_i | input | 1 | One-cycle strobe: the tester has a verdict |
| test_pass_i | input | 1 | Verdict, valid together with `test_done_i` |

## Verification
The bench targets several edge cases, and each has a telltale failure:
- **Sweep stops early.** A controller that quits once the window closes issues fewer than 32 requests.
- **Start is overwritten.** If a later pass replaced the start, a second window would pull the chosen tap upward.
- **End is kept from the first close.** With two separate windows, keeping the first closing tap instead of the last one gives a midpoint that is too low.
- **Window still open at the top.** A controller that only looks at the closed flag returns 16 instead of (start + 31) / 2.
- **Single passing tap at either edge.** Tap 0 alone passing and tap 31 alone passing probe the rounding at both ends of the range.
- **Start pulse mid-sweep.** A restart triggered by a start pulse during a sweep shows up as extra requests or as taps out of order.

// File: rtl/tws_pkg.sv
package tws_pkg;

  // Controller phases of one search run
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TEST,
    PH_GAP,
    PH_PICK,
    PH_DONE
  } phase_e;

endpackage

// File: rtl/tws_window_tracker.sv
module tws_window_tracker #(
  parameter int TAP_W  = 5,
  parameter int MARK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic              pass_i,
  input  logic [TAP_W-1:0]  tap_i,
  output logic [MARK_W-1:0] first_o,
  output logic [MARK_W-1:0] last_o,
  output logic              live_o,
  output logic              shut_o
);

  localparam logic [MARK_W-1:0] UNSEEN = '1;

  logic [MARK_W-1:0] first_q, last_q;
  logic              live_q, shut_q;
  logic [MARK_W-1:0] tap_wide;

  assign tap_wide = MARK_W'(tap_i);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      first_q <= UNSEEN;
      last_q  <= UNSEEN;
      live_q  <= 1'b0;
      shut_q  <= 1'b0;
    end else if (sample_i) begin
      if (pass_i) begin
        if (first_q == UNSEEN) first_q <= tap_wide;
        live_q <= 1'b1;
      end else if (live_q) begin
        last_q <= tap_wide;
        shut_q <= 1'b1;
        live_q <= 1'b0;
      end
    end
  end

  assign first_o = first_q;
  assign last_o  = last_q;
  assign live_o  = live_q;
  assign shut_o  = shut_q;

  // R4: once a start is recorded it stays until the next clear
  a_r4_start_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (first_q != UNSEEN) && !clear_i |=> first_q == $past(first_q));

  // R5: a fail after a pass records the closing tap and drops the live flag
  a_r5_close_edge: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i && !pass_i && live_q && !clear_i |=>
      shut_q && !live_q && (last_q == MARK_W'($past(tap_i))));

endmodule

// File: rtl/tws_pick.sv
module tws_pick #(
  parameter int TAP_W = 5,
  parameter int MARK_W = 8,
  parameter logic [TAP_W-1:0] SAFE_TAP = 5'd16
) (
  input  logic [MARK_W-1:0] first_i,
  input  logic [MARK_W-1:0] last_i,
  input  logic              live_i,
  input  logic              shut_i,
  output logic [TAP_W-1:0]  tap_o,
  output logic              ok_o
);

  localparam logic [MARK_W-1:0] TOP_TAP = MARK_W'({TAP_W{1'b1}});

  // Truncating midpoint of two tap values, carried one bit wider for the sum
  function automatic logic [TAP_W-1:0] mid_of(input logic [MARK_W-1:0] a,
                                               input logic [MARK_W-1:0] b);
    logic [MARK_W:0] sum;
    sum = {1'b0, a} + {1'b0, b};
    return TAP_W'(sum >> 1);
  endfunction

  always_comb begin
    if (shut_i)      tap_o = mid_of(first_i, last_i);
    else if (live_i) tap_o = mid_of(first_i, TOP_TAP);
    else             tap_o = SAFE_TAP;
  end

  assign ok_o = shut_i | live_i;

endmodule

// File: rtl/tws_sequencer.sv
module tws_sequencer
  import tws_pkg::*;
#(
  parameter int TAP_W = 5,
  parameter logic [TAP_W-1:0] SAFE_TAP = 5'd16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             test_done_i,
  input  logic [TAP_W-1:0] pick_tap_i,
  input  logic             pick_ok_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             test_req_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             success_o,
  output logic             sample_o,
  output logic             clear_o
);

  localparam logic [TAP_W-1:0] LAST_TAP = '1;

  phase_e           phase_q;
  logic [TAP_W-1:0] tap_q;
  logic             ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      tap_q   <= SAFE_TAP;
      ok_q    <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_TEST;
          tap_q   <= '0;
          ok_q    <= 1'b0;
        end
        PH_TEST: if (test_done_i) begin
          if (tap_q == LAST_TAP) begin
            phase_q <= PH_PICK;
          end else begin
            phase_q <= PH_GAP;
            tap_q   <= tap_q + 1'b1;
          end
        end
        PH_GAP:  phase_q <= PH_TEST;
        PH_PICK: begin
          phase_q <= PH_DONE;
          tap_q   <= pick_tap_i;
          ok_q    <= pick_ok_i;
        end
        PH_DONE: phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign tap_o      = tap_q;
  assign success_o  = ok_q;
  assign test_req_o = (phase_q == PH_TEST);
  assign busy_o     = (phase_q != PH_IDLE);
  assign done_o     = (phase_q == PH_DONE);
  assign sample_o   = (phase_q == PH_TEST) && test_done_i;
  assign clear_o    = (phase_q == PH_IDLE) && start_i;

  // R3: tap bus frozen across consecutive request cycles
  a_r3_tap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    test_req_o && $past(test_req_o) |-> $stable(tap_o));

  // R3: a verdict ends the request for at least one cycle
  a_r3_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> !test_req_o);

  // R2: taps advance by exactly one after each verdict below the top
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o && (tap_o != LAST_TAP) |=> tap_o == $past(tap_o) + 1'b1);

  // R9: done is a single-cycle pulse followed by idle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

endmodule

// File: rtl/tap_window_search.sv
module tap_window_search #(
  parameter int TAP_W  = 5,
  parameter int MARK_W = 8,
  parameter logic [TAP_W-1:0] SAFE_TAP = 5'd16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             done_o,
  output logic             busy_o,
  output logic             success_o,
  output logic [TAP_W-1:0] tap_o,
  output logic             test_req_o,
  input  logic             test_done_i,
  input  logic             test_pass_i
);

  logic              sample_w, clear_w;
  logic [MARK_W-1:0] first_w, last_w;
  logic              live_w, shut_w;
  logic [TAP_W-1:0]  pick_tap_w;
  logic              pick_ok_w;

  tws_sequencer #(.TAP_W(TAP_W), .SAFE_TAP(SAFE_TAP)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .test_done_i(test_done_i),
    .pick_tap_i (pick_tap_w),
    .pick_ok_i  (pick_ok_w),
    .tap_o      (tap_o),
    .test_req_o (test_req_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .success_o  (success_o),
    .sample_o   (sample_w),
    .clear_o    (clear_w)
  );

  tws_window_tracker #(.TAP_W(TAP_W), .MARK_W(MARK_W)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear_w),
    .sample_i(sample_w),
    .pass_i  (test_pass_i),
    .tap_i   (tap_o),
    .first_o (first_w),
    .last_o  (last_w),
    .live_o  (live_w),
    .shut_o  (shut_w)
  );

  tws_pick #(.TAP_W(TAP_W), .MARK_W(MARK_W), .SAFE_TAP(SAFE_TAP)) u_pick (
    .first_i(first_w),
    .last_i (last_w),
    .live_i (live_w),
    .shut_i (shut_w),
    .tap_o  (pick_tap_w),
    .ok_o   (pick_ok_w)
  );

  // R9: reported success matches the region flags at the done pulse
  a_r9_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> success_o == (shut_w | live_w));

  // R8: a failed search always lands on the safe tap
  a_r8_default: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !success_o |-> tap_o == SAFE_TAP);

  // R11: a fresh sweep starts with no region recorded
  a_r11_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    clear_w |=> !live_w && !shut_w);

endmodule

// File: tb/tb_tap_window_search.sv
module tb_tap_window_search;

  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic test_done_i = 1'b0;
  logic test_pass_i = 1'b0;
  logic done_o, busy_o, success_o, test_req_o;
  logic [4:0] tap_o;

  tap_window_search dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .busy_o(busy_o), .success_o(success_o), .tap_o(tap_o),
    .test_req_o(test_req_o), .test_done_i(test_done_i), .test_pass_i(test_pass_i)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [31:0] pat = '0;
  int req_cnt = 0, exp_idx = 0, order_err = 0, stable_err = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Reference: walk the verdicts and choose a tap
  function automatic void model(input logic [31:0] p, output int tap, output bit ok,
                                output string cat);
    int lo = -1, hi = -1;
    bit open_now = 0, closed = 0;
    for (int k = 0; k < 32; k++) begin
      if (p[k]) begin
        if (lo < 0) lo = k;
        open_now = 1;
      end else if (open_now) begin
        hi = k; closed = 1; open_now = 0;
      end
    end
    ok = closed || open_now;
    if (closed)        begin tap = (lo + hi) / 2; cat = "R6"; end
    else if (open_now) begin tap = (lo + 31) / 2; cat = "R7"; end
    else               begin tap = 16;            cat = "R8"; end
  endfunction

  // Pattern tester model with random latency
  initial begin
    int t;
    int d;
    forever begin
      @(negedge clk);
      if (test_req_o) begin
        t = int'(tap_o);
        d = int'($urandom_range(0, 3));
        if (t != exp_idx) order_err++;
        exp_idx++;
        req_cnt++;
        repeat (d) begin
          @(negedge clk);
          if (int'(tap_o) != t || !test_req_o) stable_err++;
        end
        test_pass_i = pat[t];
        test_done_i = 1'b1;
        @(negedge clk);
        test_done_i = 1'b0;
        test_pass_i = 1'b0;
        if (test_req_o) stable_err++;  // R3: request must drop after a verdict
      end
    end
  end

  task automatic run_sweep(input logic [31:0] p, input string ctag, input bit poke);
    int e_tap;
    bit e_ok;
    string cat;
    int guard;
    int held;
    model(p, e_tap, e_ok, cat);
    pat = p; req_cnt = 0; exp_idx = 0; order_err = 0; stable_err = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      start_i = 1'b1;           // R10: must be ignored mid-sweep
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while (!done_o && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    check(ctag, "done seen", int'(done_o), 1);
    check(ctag, $sformatf("%s chosen tap", cat), int'(tap_o), e_tap);
    check("R9", "success flag", int'(success_o), int'(e_ok));
    check(poke ? "R10" : "R2", "request count", req_cnt, 32);
    check("R2", "tap order errors", order_err, 0);
    check("R3", "tap hold errors", stable_err, 0);
    held = int'(tap_o);
    @(negedge clk);
    check("R9", "done pulse width", int'(done_o), 0);
    check("R9", "busy after done", int'(busy_o), 0);
    check("R9", "tap held after done", int'(tap_o), held);
    check("R9", "success held after done", int'(success_o), int'(e_ok));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rp;
    int lo;
    int hi;
    void'($urandom(32'h1d5e_77a3));
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "reset tap", int'(tap_o), 16);
    check("R1", "reset done", int'(done_o), 0);
    check("R1", "reset busy", int'(busy_o), 0);
    check("R1", "reset success", int'(success_o), 0);
    check("R1", "reset request", int'(test_req_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "post-reset tap", int'(tap_o), 16);

    run_sweep(32'h0000_0000, "R8", 0);                  // nothing passes -> 16
    run_sweep(32'hFFFF_FFFF, "R7", 0);                  // open at top -> 15
    run_sweep(32'h0000_0C00, "R11", 0);                 // 10..11, close 12 -> 11
    run_sweep(32'h0000_1FE0, "R6", 0);                  // 5..12, close 13 -> 9
    run_sweep(32'h8000_0000, "R7", 0);                  // only 31 -> 31
    run_sweep(32'h0000_0001, "R6", 0);                  // only 0, close 1 -> 0
    run_sweep(32'h03F0_0078, "R5", 0);                  // start 3, last close 26 -> 14
    run_sweep(32'hF000_01F0, "R4", 0);                  // start 4, close 9, reopen -> 6
    run_sweep(32'h0000_1FE0, "R10", 1);                 // ignored restart -> 9

    for (int n = 0; n < 20; n++) begin
      if (n % 3 == 0) begin
        rp = $urandom();
      end else begin
        lo = int'($urandom_range(0, 31));
        hi = int'($urandom_range(lo, 31));
        rp = '0;
        for (int k = lo; k <= hi; k++) rp[k] = 1'b1;
      end
      run_sweep(rp, "R2", 0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule